// File: doc/BRIEF.md
# Write Completion Response Scheduler

This block is the write-response side of a slave port on a memory-facing AXI interface. Every write address the master hands over becomes one queued command. The command's data beats pass straight through to core logic over a valid/ready handoff. Core logic later reports each command twice with a single-cycle pulse: once when it has taken the command in, and once when the data is safely in memory. The block chooses, for each command on its own, when the B-channel response may be given.

The choice comes from two bits sampled with the address: bit 0 of the cache field, which marks the write bufferable, and a separate completion-override bit. A non-bufferable write is answered only after memory commit. A plain bufferable write is answered as soon as its last data beat has arrived. A bufferable write with the override set is answered once core logic has accepted it. Responses always leave in address order, so a command that is already finished still waits behind an older one that is not.

Top module: `axi_wresp_sched`

## Requirements
- R1: While and after reset, s_bvalid and d_valid are low, s_wready is low and s_awready is high, because no command is held.
- R2: Each AW handshake holds one of DEPTH slots. A slot is freed only when its command has had its B handshake, its accepted pulse and its committed pulse. s_awready is low while all DEPTH slots are held.
- R3: With s_awcache[0]=0, the response is not offered until the committed pulse for that command has arrived. The value of s_awlate has no effect.
- R4: With s_awcache[0]=1 and s_awlate=0, s_bvalid rises in the cycle after the edge that transfers the command's beat with s_wlast=1, with no downstream pulse needed. Earlier beats without s_wlast do not release it.
- R5: With s_awcache[0]=1 and s_awlate=1, the response waits for both full data receipt and the accepted pulse. A committed pulse alone does not release it.
- R6: Responses are offered strictly in address order. A younger command whose condition is met is not offered while an older one is still pending.
- R7: Once s_bvalid is high it stays high, with s_bresp=2'b00 (OKAY), until a cycle with s_bready high. The command leaves the queue only on that handshake.
- R8: Each d_taken or d_done pulse is credited to the oldest command that does not yet have that indication. A pulse that arrives before the command's data has finished is remembered. A pulse sent while every held command already has it is ignored.
- R9: Write beats go to the oldest command still awaiting data. While such a command exists, s_wready equals d_ready and d_valid equals s_wvalid. At all other times both are low. d_data and d_last carry s_wdata and s_wlast unchanged in the same cycle.
- R10: Cache bits other than bit 0 have no effect on the completion policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready (a slot is free) |
| s_awcache | input | CACHE_W | Cache attributes; bit 0 marks the write bufferable |
| s_awlate | input | 1 | Completion override: wait for core acceptance |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wlast | input | 1 | Last beat of the command |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| d_valid | output | 1 | Data handoff valid toward core logic |
| d_ready | input | 1 | Core logic can take a beat |
| d_data | output | DATA_W | Data handed to core logic |
| d_last | output | 1 | Last beat marker toward core logic |
| d_taken | input | 1 | Pulse: oldest unacknowledged command accepted into core |
| d_done | input | 1 | Pulse: oldest uncommitted command written to memory |

## Verification
All queue state sits in registers, and the ready and valid outputs are derived from it through logic only. A handshake or pulse that the clock samples at one edge therefore shows up at the ports by the following falling edge and not earlier. The bench drives every input on a falling edge and updates its own model of the queue from what the next rising edge will sample. It compares s_bvalid, s_awready, s_wready, d_valid and the pass-through data one falling edge later. Directed scenarios add checks at those same falling edges on the exact cycle a response must appear, for example the cycle after the WLAST edge for a plain bufferable write, and on the cycles where it must still be held back.

// File: rtl/axi_wresp_pkg.sv
package axi_wresp_pkg;

   // Completion point chosen per command
   typedef enum logic [1:0] {
      CPL_PORT   = 2'd0,   // last data beat received at the port
      CPL_CORE   = 2'd1,   // accepted into core logic
      CPL_MEMORY = 2'd2    // committed to memory
   } cpl_pol_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   // Sequence counters kept by the scheduler
   localparam int SEQ_ALLOC = 0;
   localparam int SEQ_POP   = 1;
   localparam int SEQ_DATA  = 2;
   localparam int SEQ_TAKEN = 3;
   localparam int SEQ_DONE  = 4;
   localparam int SEQ_N     = 5;

   function automatic cpl_pol_e pick_policy(input logic bufferable, input logic late);
      if (!bufferable) return CPL_MEMORY;
      if (late)        return CPL_CORE;
      return CPL_PORT;
   endfunction

endpackage

// File: rtl/wresp_seq_ctr.sv
module wresp_seq_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/wresp_pol_store.sv
module wresp_pol_store
   import axi_wresp_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  cpl_pol_e      wr_pol,
   input  logic [IW-1:0] rd_idx,
   output cpl_pol_e      rd_pol
);

   cpl_pol_e slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[g] <= CPL_PORT;
         else if (wr_en && (wr_idx == IW'(g)))
            slot_q[g] <= wr_pol;
      end
   end

   assign rd_pol = slot_q[rd_idx];

endmodule

// File: rtl/wresp_release.sv
module wresp_release
   import axi_wresp_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic [CW-1:0] alloc_seq,
   input  logic [CW-1:0] pop_seq,
   input  logic [CW-1:0] data_seq,
   input  logic [CW-1:0] taken_seq,
   input  logic [CW-1:0] done_seq,
   input  cpl_pol_e      head_pol,
   output logic          head_ok,
   output logic          data_open,
   output logic          taken_open,
   output logic          done_open,
   output logic [CW-1:0] slots_used
);

   // Distances from the allocation counter. Each one lies in 0..DEPTH.
   logic [CW-1:0] d_pop, d_data, d_taken, d_done, m_a;
   logic          head_live, head_data, head_taken, head_done;

   always_comb begin
      d_pop   = alloc_seq - pop_seq;
      d_data  = alloc_seq - data_seq;
      d_taken = alloc_seq - taken_seq;
      d_done  = alloc_seq - done_seq;

      head_live  = (d_pop != '0);
      // The head has an indication when that counter has moved past it
      head_data  = (d_data  < d_pop);
      head_taken = (d_taken < d_pop);
      head_done  = (d_done  < d_pop);

      unique case (head_pol)
         CPL_CORE:   head_ok = head_live && head_data && head_taken;
         CPL_MEMORY: head_ok = head_live && head_data && head_done;
         default:    head_ok = head_live && head_data;
      endcase

      data_open  = (d_data  != '0);
      taken_open = (d_taken != '0);
      done_open  = (d_done  != '0);

      m_a        = (d_pop > d_taken) ? d_pop : d_taken;
      slots_used = (m_a > d_done) ? m_a : d_done;
   end

endmodule

// File: rtl/axi_wresp_sched.sv
module axi_wresp_sched
   import axi_wresp_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int DATA_W  = 32,
   parameter int CACHE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_awvalid,
   output logic               s_awready,
   input  logic [CACHE_W-1:0] s_awcache,
   input  logic               s_awlate,
   input  logic               s_wvalid,
   output logic               s_wready,
   input  logic [DATA_W-1:0]  s_wdata,
   input  logic               s_wlast,
   output logic               s_bvalid,
   input  logic               s_bready,
   output logic [1:0]         s_bresp,
   output logic               d_valid,
   input  logic               d_ready,
   output logic [DATA_W-1:0]  d_data,
   output logic               d_last,
   input  logic               d_taken,
   input  logic               d_done
);

   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("axi_wresp_sched: DEPTH must be a power of two of at least 2");
   end
   if (CACHE_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("axi_wresp_sched: CACHE_W and DATA_W must be at least 1");
   end

   logic [SEQ_N-1:0] bump;
   logic [CW-1:0]    seq_q [SEQ_N];
   logic             head_ok, data_open, taken_open, done_open;
   logic [CW-1:0]    slots_used;
   cpl_pol_e         head_pol;
   logic             aw_hs;

   for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
      wresp_seq_ctr #(.CW(CW)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (bump[g]),
         .cnt   (seq_q[g])
      );
   end

   wresp_pol_store #(.DEPTH(DEPTH)) u_pol (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (aw_hs),
      .wr_idx (seq_q[SEQ_ALLOC][IW-1:0]),
      .wr_pol (pick_policy(s_awcache[0], s_awlate)),
      .rd_idx (seq_q[SEQ_POP][IW-1:0]),
      .rd_pol (head_pol)
   );

   wresp_release #(.CW(CW)) u_rel (
      .alloc_seq  (seq_q[SEQ_ALLOC]),
      .pop_seq    (seq_q[SEQ_POP]),
      .data_seq   (seq_q[SEQ_DATA]),
      .taken_seq  (seq_q[SEQ_TAKEN]),
      .done_seq   (seq_q[SEQ_DONE]),
      .head_pol   (head_pol),
      .head_ok    (head_ok),
      .data_open  (data_open),
      .taken_open (taken_open),
      .done_open  (done_open),
      .slots_used (slots_used)
   );

   // Upper cache bits play no part in the completion decision
   logic unused_cache_hi;
   if (CACHE_W > 1) begin : g_cache_hi
      assign unused_cache_hi = ^s_awcache[CACHE_W-1:1];
   end else begin : g_cache_one
      assign unused_cache_hi = 1'b0;
   end

   always_comb begin
      s_awready = (slots_used < CW'(DEPTH));
      aw_hs     = s_awvalid && s_awready;

      s_wready  = data_open && d_ready;
      d_valid   = data_open && s_wvalid;
      d_data    = s_wdata;
      d_last    = s_wlast;

      s_bvalid  = head_ok;
      s_bresp   = RESP_OKAY;

      bump[SEQ_ALLOC] = aw_hs;
      bump[SEQ_POP]   = s_bvalid && s_bready;
      bump[SEQ_DATA]  = s_wvalid && s_wready && s_wlast;
      bump[SEQ_TAKEN] = d_taken && taken_open;
      bump[SEQ_DONE]  = d_done && done_open;
   end

endmodule

// File: rtl/wresp_sched_chk.sv
module wresp_sched_chk #(
   parameter int DEPTH = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s_awvalid,
   input logic       s_awready,
   input logic       s_wvalid,
   input logic       s_wready,
   input logic       s_bvalid,
   input logic       s_bready,
   input logic [1:0] s_bresp,
   input logic       d_valid,
   input logic       d_ready
);

   localparam int LW = $clog2(DEPTH + 1) + 1;

   // Commands accepted but not yet answered
   logic [LW-1:0] wait_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else wait_q <= wait_q + LW'(s_awvalid && s_awready) - LW'(s_bvalid && s_bready);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!s_bvalid && !d_valid && !s_wready));

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= LW'(DEPTH));

   // R2
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q == LW'(DEPTH)) |-> !s_awready);

   // R7
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

   // R7
   bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> (s_bresp == 2'b00));

   // R6
   b_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> (wait_q != '0));

   // R9
   w_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_wready |-> d_ready);

   // R9
   dvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> s_wvalid);

endmodule

bind axi_wresp_sched wresp_sched_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_awvalid (s_awvalid),
   .s_awready (s_awready),
   .s_wvalid  (s_wvalid),
   .s_wready  (s_wready),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .s_bresp   (s_bresp),
   .d_valid   (d_valid),
   .d_ready   (d_ready)
);

// File: tb/sim_axi_wresp_sched.sv
`timescale 1ns/1ps
module sim_axi_wresp_sched;

   localparam int DEPTH  = 8;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              s_awvalid = 1'b0, s_awlate = 1'b0;
   logic [3:0]        s_awcache = '0;
   logic              s_awready;
   logic              s_wvalid = 1'b0, s_wlast = 1'b0, s_wready;
   logic [DATA_W-1:0] s_wdata = '0;
   logic              s_bvalid, s_bready = 1'b0;
   logic [1:0]        s_bresp;
   logic              d_valid, d_ready = 1'b0, d_last;
   logic [DATA_W-1:0] d_data;
   logic              d_taken = 1'b0, d_done = 1'b0;

   always #4 clk = ~clk;

   axi_wresp_sched #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CACHE_W(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awcache(s_awcache), .s_awlate(s_awlate),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .d_valid(d_valid), .d_ready(d_ready), .d_data(d_data), .d_last(d_last),
      .d_taken(d_taken), .d_done(d_done)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // Reference model: policy 0 = port, 1 = core, 2 = memory
   int pol_m [256];
   int n_alloc = 0, n_pop = 0, n_dat = 0, n_acc = 0, n_com = 0;

   function automatic int pol_of(input logic [3:0] cache, input bit late);
      if (!cache[0]) return 2;
      return late ? 1 : 0;
   endfunction

   function automatic int min3(input int a, input int b, input int c);
      int m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      return m;
   endfunction

   function automatic bit exp_bvalid();
      int p;
      if (n_pop >= n_alloc) return 1'b0;
      if (n_dat <= n_pop)   return 1'b0;
      p = pol_m[n_pop % 256];
      if (p == 1) return n_acc > n_pop;
      if (p == 2) return n_com > n_pop;
      return 1'b1;
   endfunction

   function automatic bit exp_awready();
      return (n_alloc - min3(n_pop, n_acc, n_com)) < DEPTH;
   endfunction

   function automatic bit data_pending();
      return n_dat < n_alloc;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Port checks against the model, taken at a falling edge
   task automatic port_checks();
      chk(s_bvalid == exp_bvalid(), "R6 order/policy bvalid", s_bvalid, exp_bvalid());
      chk(s_awready == exp_awready(), "R2 awready", s_awready, exp_awready());
      chk(s_wready == (data_pending() && d_ready), "R9 wready", s_wready, data_pending() && d_ready);
      chk(d_valid == (data_pending() && s_wvalid), "R9 d_valid", d_valid, data_pending() && s_wvalid);
      chk(d_data == s_wdata && d_last == s_wlast, "R9 pass-through", int'(d_data), int'(s_wdata));
      if (s_bvalid) chk(s_bresp == 2'b00, "R7 bresp", s_bresp, 0);
   endtask

   // One clock: drive at a falling edge, model the next rising edge, check at the next falling edge
   task automatic step(input bit aw, input logic [3:0] cache, input bit late,
                       input bit wv, input bit wl, input bit dr,
                       input bit tk, input bit dn, input bit br);
      bit aw_hs, wl_hs, tk_ok, dn_ok, b_hs;
      s_awvalid = aw; s_awcache = cache; s_awlate = late;
      s_wvalid = wv; s_wlast = wl; s_wdata = $urandom; d_ready = dr;
      d_taken = tk; d_done = dn; s_bready = br;
      #1;
      port_checks();
      aw_hs = aw && exp_awready();
      wl_hs = wv && wl && dr && data_pending();
      tk_ok = tk && (n_acc < n_alloc);
      dn_ok = dn && (n_com < n_alloc);
      b_hs  = br && exp_bvalid();
      if (aw_hs) begin pol_m[n_alloc % 256] = pol_of(cache, late); n_alloc++; end
      if (wl_hs) n_dat++;
      if (tk_ok) n_acc++;
      if (dn_ok) n_com++;
      if (b_hs)  n_pop++;
      @(negedge clk);
      port_checks();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 4'd0, 0, 0, 0, 1, 0, 0, 0);
   endtask
   task automatic put_aw(input logic [3:0] cache, input bit late);
      step(1, cache, late, 0, 0, 1, 0, 0, 0);
   endtask
   task automatic put_w(input bit last);
      step(0, 4'd0, 0, 1, last, 1, 0, 0, 0);
   endtask
   task automatic pulse(input bit tk, input bit dn);
      step(0, 4'd0, 0, 0, 0, 1, tk, dn, 0);
   endtask
   task automatic take_b();
      step(0, 4'd0, 0, 0, 0, 1, 0, 0, 1);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #1600000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      // R1: quiet while in reset, even with write data offered
      s_wvalid = 1'b1; d_ready = 1'b1;
      #1;
      chk(!s_bvalid && !d_valid && !s_wready && s_awready, "R1 in reset",
          {s_bvalid, d_valid, s_wready, s_awready}, 4'b0001);
      s_wvalid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!s_bvalid && !d_valid && s_awready, "R1 after reset", {s_bvalid, d_valid, s_awready}, 1);

      // R4 + R7: bufferable write, three beats
      put_aw(4'b0001, 0);
      put_w(0); put_w(0);
      chk(s_bvalid == 1'b0, "R4 not before last beat", s_bvalid, 0);
      put_w(1);
      chk(s_bvalid == 1'b1, "R4 ready after last beat", s_bvalid, 1);
      idle(3);
      chk(s_bvalid == 1'b1, "R7 held without bready", s_bvalid, 1);
      take_b();
      chk(s_bvalid == 1'b0, "R7 popped on handshake", s_bvalid, 0);
      pulse(1, 1);

      // R3: non-bufferable, override set but ignored
      put_aw(4'b0000, 1);
      put_w(1);
      chk(s_bvalid == 1'b0, "R3 wait after data", s_bvalid, 0);
      pulse(1, 0);
      chk(s_bvalid == 1'b0, "R3 accepted is not enough", s_bvalid, 0);
      pulse(0, 1);
      chk(s_bvalid == 1'b1, "R3 released on commit", s_bvalid, 1);
      take_b();

      // R5: bufferable with override
      put_aw(4'b0001, 1);
      put_w(1);
      chk(s_bvalid == 1'b0, "R5 wait after data", s_bvalid, 0);
      pulse(0, 1);
      chk(s_bvalid == 1'b0, "R5 commit does not release", s_bvalid, 0);
      pulse(1, 0);
      chk(s_bvalid == 1'b1, "R5 released on accepted", s_bvalid, 1);
      take_b();

      // R8: accepted pulse before data finishes
      put_aw(4'b0001, 1);
      pulse(1, 0);
      put_w(1);
      chk(s_bvalid == 1'b1, "R8 early pulse remembered", s_bvalid, 1);
      take_b();
      pulse(0, 1);

      // R6: younger finished command waits behind older
      put_aw(4'b0000, 0);
      put_aw(4'b0001, 0);
      put_w(1); put_w(1);
      chk(s_bvalid == 1'b0, "R6 younger held behind older", s_bvalid, 0);
      pulse(1, 0); pulse(1, 0);
      pulse(0, 1);
      chk(s_bvalid == 1'b1, "R6 older released", s_bvalid, 1);
      take_b();
      chk(s_bvalid == 1'b1, "R6 younger follows", s_bvalid, 1);
      take_b();
      pulse(0, 1);

      // R8: pulse with nothing outstanding is dropped
      pulse(1, 1);
      put_aw(4'b0001, 1);
      put_w(1);
      chk(s_bvalid == 1'b0, "R8 stray pulse ignored", s_bvalid, 0);
      pulse(1, 0);
      take_b();
      pulse(0, 1);

      // R10: upper cache bits set, bit 0 clear -> memory policy
      put_aw(4'b1110, 0);
      put_w(1);
      chk(s_bvalid == 1'b0, "R10 upper bits ignored", s_bvalid, 0);
      pulse(1, 1);
      chk(s_bvalid == 1'b1, "R10 commit releases", s_bvalid, 1);
      take_b();

      // R2: fill every slot
      for (int i = 0; i < DEPTH; i++) put_aw(4'b0001, 0);
      chk(s_awready == 1'b0, "R2 full after DEPTH commands", s_awready, 0);
      for (int i = 0; i < DEPTH; i++) put_w(1);
      for (int i = 0; i < DEPTH; i++) take_b();
      chk(s_awready == 1'b0, "R2 slots held until pulses", s_awready, 0);
      for (int i = 0; i < DEPTH; i++) pulse(1, 1);
      chk(s_awready == 1'b1, "R2 slots freed", s_awready, 1);

      // Random traffic checked against the model
      for (int c = 0; c < 4000; c++) begin
         step(($urandom % 10) < 4, 4'($urandom), $urandom % 2,
              ($urandom % 10) < 6, ($urandom % 10) < 4, ($urandom % 10) < 8,
              ($urandom % 10) < 3, ($urandom % 10) < 3, ($urandom % 10) < 6);
      end
      // drain
      for (int c = 0; c < 200; c++) step(0, 4'd0, 0, 1, 1, 1, 1, 1, 1);
      chk(s_awready == 1'b1 && s_bvalid == 1'b0, "R2 drained", {s_awready, s_bvalid}, 2);

      finish_run();
   end

endmodule